// File: doc/BRIEF.md
# TLB Lookup Unit

The block translates a 32-bit virtual address through a small, fully associative table of page entries. Each entry records its own page size (1 KB, 4 KB, 64 KB or 1 MB), an address-space tag, a shared flag, access rights, a dirty flag and two cache attributes. One request per cycle is taken. The lookup itself is combinational. The outcome is registered: a 29-bit physical address, a fault flag with a 12-bit fault code, the cache attributes of the hit entry and the captured faulting address.

Two address windows are never translated: the window from 0x80000000 up to 0xBFFFFFFF, and everything from 0xE0000000 upward. A global enable can also switch translation off. Software fills the table through the pair of page-table words and a load strobe. The slot that gets written is chosen by a 6-bit replacement counter. This counter moves on every request that goes through the table, and wraps back to zero at a software-set boundary or at the last slot.

Top module: `tlb_xlate`

## Requirements
- R1: rsp_valid_o is 1 in exactly the cycle after each cycle in which req_i is 1, and 0 otherwise.
- R2: An entry with size code sz (0=1 KB, 1=4 KB, 2=64 KB, 3=1 MB) matches when the request address lies in the page starting at {vpn,10'b0} rounded down to that size. A permitted hit returns paddr = ({ppn,10'b0} with the offset bits cleared) OR (address offset bits), fault 0, code 0x000, and rsp_attr_o = {cacheable, write_through}. The outputs paddr and attr are 0 whenever fault is 1.
- R3: Only valid entries match. The tag is compared only when single_virt_i=0 and priv_i=0. An entry whose shared flag is set ignores the tag.
- R4: A request that hits two or more entries faults with code 0x140.
- R5: In privileged mode, an address in 0x80000000–0xBFFFFFFF or at 0xE0000000 and above gives paddr = address[28:0] with no fault, whatever the table holds.
- R6: In user mode, those windows give a miss fault (0x040 for a read, 0x060 for a write). The one exception is 0xE0000000–0xE4000000 inclusive, which is passed through as in R5.
- R7: With xlate_en_i=0, any address outside the R5 windows gives paddr = address[28:0] with no fault.
- R8: The access right is looked up by {prot[1:0], priv_i}. Indices 0 and 2 deny all access. Indices 1, 4 and 5 are read-only. Indices 3, 6 and 7 allow read and write. A denied read gives 0x0A0 and a denied write gives 0x0C0.
- R9: A write that is permitted, to an entry whose dirty flag is 0, faults with code 0x080.
- R10: A translated request that hits no entry faults with 0x040 for a read and 0x060 for a write.
- R11: rsp_fault_addr_o takes the request address on every faulting request and holds its value otherwise.
- R12: Only requests that go through the table change repl_ctr_o. Such a request sets c' = c+1, or 0 when c+1 equals repl_bound_i or N_ENTRIES-1.
- R13: load_i writes the slot repl_ctr_o with fields taken from two words. From pt_hi_i: vpn=[31:10] and tag=[7:0]. From pt_lo_i: ppn=[28:10], valid=[8], size=[7:6], prot=[5:4], cacheable=[3], dirty=[2], shared=[1], write_through=[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Lookup request |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| req_vaddr_i | input | 32 | Virtual address |
| priv_i | input | 1 | Privileged mode |
| xlate_en_i | input | 1 | Translation enable |
| single_virt_i | input | 1 | Single virtual space (tag compare off) |
| cur_asid_i | input | 8 | Current address-space tag |
| repl_bound_i | input | 6 | Replacement counter wrap boundary |
| load_i | input | 1 | Write the page-table words into the table |
| pt_hi_i | input | 32 | Page-table high word |
| pt_lo_i | input | 32 | Page-table low word |
| rsp_valid_o | output | 1 | Response valid |
| rsp_fault_o | output | 1 | Request faulted |
| rsp_code_o | output | 12 | Fault code, 0 when there is no fault |
| rsp_paddr_o | output | 29 | Physical address |
| rsp_attr_o | output | 2 | {cacheable, write_through} of the hit entry |
| rsp_fault_addr_o | output | 32 | Address of the most recent faulting request |
| repl_ctr_o | output | 6 | Replacement counter |

## Verification
The embedded properties assume that repl_bound_i is held stable across a request and the following cycle. They also assume that the table's contents at the time of a request are exactly what was loaded before that request. The stimulus changes the boundary only between requests. It issues every load in a cycle with no request outstanding, and it keeps each request to a single cycle followed by an idle cycle, so every response can be matched to the request that caused it.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 29;
  localparam int VPN_W  = 22;
  localparam int PPN_W  = 19;
  localparam int ASID_W = 8;
  localparam int CODE_W = 12;

  typedef struct packed {
    logic              v;
    logic [ASID_W-1:0] asid;
    logic              sh;
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic [1:0]        sz;
    logic [1:0]        pr;
    logic              d;
    logic              c;
    logic              wt;
  } tlb_entry_t;

  typedef enum logic [1:0] {RIGHTS_NONE, RIGHTS_RO, RIGHTS_RW} rights_e;

  localparam logic [CODE_W-1:0] CODE_OK      = 12'h000;
  localparam logic [CODE_W-1:0] CODE_MISS_RD = 12'h040;
  localparam logic [CODE_W-1:0] CODE_MISS_WR = 12'h060;
  localparam logic [CODE_W-1:0] CODE_INIT_WR = 12'h080;
  localparam logic [CODE_W-1:0] CODE_VIOL_RD = 12'h0A0;
  localparam logic [CODE_W-1:0] CODE_VIOL_WR = 12'h0C0;
  localparam logic [CODE_W-1:0] CODE_MULTI   = 12'h140;

  // offset bits of a page for each size code
  function automatic logic [VA_W-1:0] page_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    page_mask = 32'h0000_03FF;
      2'd1:    page_mask = 32'h0000_0FFF;
      2'd2:    page_mask = 32'h0000_FFFF;
      default: page_mask = 32'h000F_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/tlb_rights.sv
module tlb_rights
  import tlb_pkg::*;
(
  input  logic [1:0] prot_i,
  input  logic       priv_i,
  output rights_e    rights_o
);
  always_comb begin
    case ({prot_i, priv_i})
      3'd0, 3'd2:       rights_o = RIGHTS_NONE;
      3'd1, 3'd4, 3'd5: rights_o = RIGHTS_RO;
      default:          rights_o = RIGHTS_RW;
    endcase
  end
endmodule

// File: rtl/tlb_repl_ctr.sv
module tlb_repl_ctr #(
  parameter int N_ENTRIES = 64,
  parameter int CTR_W     = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [CTR_W-1:0] bound_i,
  output logic [CTR_W-1:0] ctr_o
);
  localparam logic [CTR_W-1:0] LAST = CTR_W'(N_ENTRIES - 1);

  logic [CTR_W-1:0] ctr_q, ctr_inc;

  assign ctr_inc = ctr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctr_q <= '0;
    else if (step_i) ctr_q <= (ctr_inc == bound_i || ctr_inc == LAST) ? '0 : ctr_inc;
  end

  assign ctr_o = ctr_q;

  p_ctr_bound_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctr_q < LAST);
  p_ctr_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(ctr_q));
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 64,
  parameter int CTR_W     = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [CTR_W-1:0]     load_idx_i,
  input  tlb_entry_t           load_entry_i,
  input  logic [VA_W-1:0]      vaddr_i,
  input  logic                 use_asid_i,
  input  logic [ASID_W-1:0]    asid_i,
  output logic [N_ENTRIES-1:0] hit_vec_o,
  output tlb_entry_t           hit_entry_o
);
  localparam int EW = $bits(tlb_entry_t);

  logic [N_ENTRIES-1:0][EW-1:0] masked;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    tlb_entry_t      ent_q;
    logic [VA_W-1:0] mask, base;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   ent_q <= '0;
      else if (load_i && load_idx_i == CTR_W'(g))    ent_q <= load_entry_i;
    end

    assign mask         = page_mask(ent_q.sz);
    assign base         = {ent_q.vpn, 10'b0};
    assign hit_vec_o[g] = ent_q.v
                        && (!use_asid_i || ent_q.sh || ent_q.asid == asid_i)
                        && (((vaddr_i ^ base) & ~mask) == '0);
    assign masked[g]    = hit_vec_o[g] ? ent_q : '0;
  end

  always_comb begin
    logic [EW-1:0] acc;
    acc = '0;
    for (int i = 0; i < N_ENTRIES; i++) acc = acc | masked[i];
    hit_entry_o = tlb_entry_t'(acc);
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 64,
  parameter int CTR_W     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_write_i,
  input  logic [31:0]       req_vaddr_i,
  input  logic              priv_i,
  input  logic              xlate_en_i,
  input  logic              single_virt_i,
  input  logic [7:0]        cur_asid_i,
  input  logic [CTR_W-1:0]  repl_bound_i,
  input  logic              load_i,
  input  logic [31:0]       pt_hi_i,
  input  logic [31:0]       pt_lo_i,
  output logic              rsp_valid_o,
  output logic              rsp_fault_o,
  output logic [11:0]       rsp_code_o,
  output logic [28:0]       rsp_paddr_o,
  output logic [1:0]        rsp_attr_o,
  output logic [31:0]       rsp_fault_addr_o,
  output logic [CTR_W-1:0]  repl_ctr_o
);
  logic [N_ENTRIES-1:0] hit_vec;
  tlb_entry_t           hit_ent, ld_ent;
  rights_e              rights;
  logic                 fixed_win, user_win, use_asid, arr_lookup;
  logic                 any_hit, multi_hit;
  logic [CODE_W-1:0]    nxt_code;
  logic [PA_W-1:0]      nxt_pa, off_mask;
  logic [1:0]           nxt_attr;
  logic                 unused_bits;

  assign fixed_win  = (req_vaddr_i[31:30] == 2'b10) || (req_vaddr_i[31:29] == 3'b111);
  assign user_win   = (req_vaddr_i >= 32'hE000_0000) && (req_vaddr_i <= 32'hE400_0000);
  assign use_asid   = !single_virt_i && !priv_i;
  assign arr_lookup = req_i && xlate_en_i && !fixed_win;
  assign any_hit    = |hit_vec;
  assign multi_hit  = |(hit_vec & (hit_vec - 1'b1));

  assign ld_ent = '{v:    pt_lo_i[8],
                    asid: pt_hi_i[7:0],
                    sh:   pt_lo_i[1],
                    vpn:  pt_hi_i[31:10],
                    ppn:  pt_lo_i[28:10],
                    sz:   pt_lo_i[7:6],
                    pr:   pt_lo_i[5:4],
                    d:    pt_lo_i[2],
                    c:    pt_lo_i[3],
                    wt:   pt_lo_i[0]};

  assign unused_bits = ^{pt_hi_i[9:8], pt_lo_i[31:29], pt_lo_i[9],
                         hit_ent.v, hit_ent.asid, hit_ent.sh, hit_ent.vpn};

  tlb_entry_array #(.N_ENTRIES(N_ENTRIES), .CTR_W(CTR_W)) u_array (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load_i),
    .load_idx_i   (repl_ctr_o),
    .load_entry_i (ld_ent),
    .vaddr_i      (req_vaddr_i),
    .use_asid_i   (use_asid),
    .asid_i       (cur_asid_i),
    .hit_vec_o    (hit_vec),
    .hit_entry_o  (hit_ent)
  );

  tlb_repl_ctr #(.N_ENTRIES(N_ENTRIES), .CTR_W(CTR_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (arr_lookup),
    .bound_i (repl_bound_i),
    .ctr_o   (repl_ctr_o)
  );

  tlb_rights u_rights (
    .prot_i   (hit_ent.pr),
    .priv_i   (priv_i),
    .rights_o (rights)
  );

  assign off_mask = PA_W'(page_mask(hit_ent.sz));

  always_comb begin
    nxt_code = CODE_OK;
    nxt_pa   = '0;
    nxt_attr = '0;
    if (fixed_win) begin
      if (!priv_i && !user_win) nxt_code = req_write_i ? CODE_MISS_WR : CODE_MISS_RD;
      else                      nxt_pa   = req_vaddr_i[PA_W-1:0];
    end else if (!xlate_en_i) begin
      nxt_pa = req_vaddr_i[PA_W-1:0];
    end else if (multi_hit) begin
      nxt_code = CODE_MULTI;
    end else if (!any_hit) begin
      nxt_code = req_write_i ? CODE_MISS_WR : CODE_MISS_RD;
    end else begin
      case (rights)
        RIGHTS_NONE: nxt_code = req_write_i ? CODE_VIOL_WR : CODE_VIOL_RD;
        RIGHTS_RO:   if (req_write_i) nxt_code = CODE_VIOL_WR;
        default:     ;
      endcase
      if (nxt_code == CODE_OK && req_write_i && !hit_ent.d) nxt_code = CODE_INIT_WR;
      if (nxt_code == CODE_OK) begin
        nxt_pa   = ({hit_ent.ppn, 10'b0} & ~off_mask) | (req_vaddr_i[PA_W-1:0] & off_mask);
        nxt_attr = {hit_ent.c, hit_ent.wt};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o      <= 1'b0;
      rsp_fault_o      <= 1'b0;
      rsp_code_o       <= '0;
      rsp_paddr_o      <= '0;
      rsp_attr_o       <= '0;
      rsp_fault_addr_o <= '0;
    end else begin
      rsp_valid_o <= req_i;
      if (req_i) begin
        rsp_fault_o <= (nxt_code != CODE_OK);
        rsp_code_o  <= nxt_code;
        rsp_paddr_o <= nxt_pa;
        rsp_attr_o  <= nxt_attr;
        if (nxt_code != CODE_OK) rsp_fault_addr_o <= req_vaddr_i;
      end
    end
  end

  p_valid_after_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  p_no_spurious_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);
  p_multi_code_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_lookup && $countones(hit_vec) > 1) |=> (rsp_fault_o && rsp_code_o == CODE_MULTI));
  p_bypass_clean_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !xlate_en_i && !fixed_win) |=> (!rsp_fault_o && rsp_paddr_o == $past(req_vaddr_i[PA_W-1:0])));
  p_fault_addr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(rsp_fault_addr_o));
  p_fault_zero_pa_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> (rsp_paddr_o == '0 && rsp_attr_o == '0));
endmodule

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0, priv = 1'b0, en = 1'b1, sv = 1'b0, load = 1'b0;
  logic [31:0] va = '0, pt_hi = '0, pt_lo = '0;
  logic [7:0]  asid = '0;
  logic [5:0]  bound = '0;
  logic        v_o, f_o;
  logic [11:0] code_o;
  logic [28:0] pa_o;
  logic [1:0]  attr_o;
  logic [31:0] fa_o;
  logic [5:0]  ctr_o;

  int n_chk = 0, n_bad = 0;

  bit [31:0] m_vb [N];
  bit [31:0] m_pb [N];
  bit [1:0]  m_sz [N], m_pr [N];
  bit [7:0]  m_as [N];
  bit        m_v [N], m_sh [N], m_d [N], m_c [N], m_wt [N];
  bit [5:0]  e_ctr = 0;
  bit [31:0] e_fa = 0;

  always #5 clk = ~clk;

  tlb_xlate #(.N_ENTRIES(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_write_i(wr), .req_vaddr_i(va),
    .priv_i(priv), .xlate_en_i(en), .single_virt_i(sv), .cur_asid_i(asid),
    .repl_bound_i(bound), .load_i(load), .pt_hi_i(pt_hi), .pt_lo_i(pt_lo),
    .rsp_valid_o(v_o), .rsp_fault_o(f_o), .rsp_code_o(code_o), .rsp_paddr_o(pa_o),
    .rsp_attr_o(attr_o), .rsp_fault_addr_o(fa_o), .repl_ctr_o(ctr_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] sz_bytes(input bit [1:0] s);
    return 32'd1 << (s == 0 ? 10 : s == 1 ? 12 : s == 2 ? 16 : 20);
  endfunction

  task automatic load_slot(input bit [31:0] vb, input bit [31:0] pb, input bit [1:0] sz,
                           input bit [1:0] pr, input bit [7:0] as, input bit sh,
                           input bit d, input bit c, input bit wt);
    int k = int'(e_ctr);
    m_v[k] = 1; m_vb[k] = {vb[31:10], 10'b0}; m_pb[k] = {3'b0, pb[28:10], 10'b0};
    m_sz[k] = sz; m_pr[k] = pr; m_as[k] = as; m_sh[k] = sh; m_d[k] = d; m_c[k] = c; m_wt[k] = wt;
    @(negedge clk);
    pt_hi = {vb[31:10], 2'b00, as};
    pt_lo = {3'b0, pb[28:10], 1'b0, 1'b1, sz, pr, c, d, sh, wt};
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic look(input bit [31:0] a, input bit w, input bit p, input bit s,
                      input bit [7:0] as, input bit e, input string tag);
    bit [11:0] ec = 12'h000;
    bit [28:0] ep = '0;
    bit [1:0]  eat = '0;
    bit fixed, win, ua, xl;
    int nh = 0, hi = 0;
    string t;
    fixed = (a >= 32'h8000_0000 && a <= 32'hBFFF_FFFF) || a >= 32'hE000_0000;
    win   = a >= 32'hE000_0000 && a <= 32'hE400_0000;
    ua    = !s && !p;
    xl    = e && !fixed;
    if (fixed) begin
      if (!p && !win) ec = w ? 12'h060 : 12'h040; else ep = a[28:0];
    end else if (!e) ep = a[28:0];
    else begin
      for (int i = 0; i < N; i++) begin
        bit [31:0] st, sb;
        sb = sz_bytes(m_sz[i]);
        st = m_vb[i] & ~(sb - 1);
        if (m_v[i] && (!ua || m_sh[i] || m_as[i] == as) && a >= st && a <= st + (sb - 1)) begin
          nh++; hi = i;
        end
      end
      if (nh > 1) ec = 12'h140;
      else if (nh == 0) ec = w ? 12'h060 : 12'h040;
      else begin
        int idx = int'(m_pr[hi]) * 2 + int'(p);
        if (idx == 0 || idx == 2) ec = w ? 12'h0C0 : 12'h0A0;
        else if ((idx == 1 || idx == 4 || idx == 5) && w) ec = 12'h0C0;
        else if (w && !m_d[hi]) ec = 12'h080;
        if (ec == 0) begin
          bit [31:0] sb = sz_bytes(m_sz[hi]);
          ep  = 29'((m_pb[hi] & ~(sb - 1)) | (a & (sb - 1)));
          eat = {m_c[hi], m_wt[hi]};
        end
      end
    end
    if (ec != 0) e_fa = a;
    if (xl) e_ctr = (e_ctr + 1 == bound || e_ctr + 1 == 6'(N - 1)) ? 6'd0 : e_ctr + 1;
    case (ec)
      12'h140:          t = {tag, " R4"};
      12'h0A0, 12'h0C0: t = {tag, " R8"};
      12'h080:          t = {tag, " R9"};
      12'h040, 12'h060: t = {tag, " R10"};
      default:          t = {tag, " R2"};
    endcase
    @(negedge clk);
    va = a; wr = w; priv = p; sv = s; asid = as; en = e; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk("R1 valid", 32'(v_o), 32'd1);
    chk({t, " code"}, 32'(code_o), 32'(ec));
    chk({t, " fault"}, 32'(f_o), 32'(ec != 0));
    chk({t, " paddr"}, 32'(pa_o), 32'(ep));
    chk({t, " R13 attr"}, 32'(attr_o), 32'(eat));
    chk("R11 fault addr", fa_o, e_fa);
    chk("R12 counter", 32'(ctr_o), 32'(e_ctr));
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < N; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset valid", 32'(v_o), 0);
    chk("R10 reset fault", 32'(f_o), 0);
    chk("R11 reset fault addr", fa_o, 0);
    chk("R12 reset counter", 32'(ctr_o), 0);

    // empty table: misses
    look(32'h0000_1000, 0, 1, 0, 8'h00, 1, "R10 empty");
    look(32'h0000_2000, 1, 0, 0, 8'h00, 1, "R10 empty");

    // bounded wrap
    bound = 6'd3;
    for (int i = 0; i < 4; i++) look(32'h0000_3000, 0, 1, 0, 8'h00, 1, "R12 bound");
    bound = 6'd0;
    // bring counter back to 0
    while (e_ctr != 0) look(32'h0000_3000, 0, 1, 0, 8'h00, 1, "R12 realign");

    // fill slots 0..6 (N-1 wrap)
    for (int s = 0; s < 7; s++) begin
      if (s < 6)
        load_slot(((s + 1) << 20) + 32'h400, 32'h0234_5400 + s * 32'h0100_0000,
                  2'(s % 4), 2'((s + 1) % 4), 8'(s), s == 2, s[0], s[1], s[2]);
      else
        load_slot(32'h0010_0000, 32'h0ABC_0000, 2'd3, 2'd3, 8'd6, 1'b1, 1'b1, 1'b0, 1'b1);
      look(32'h0000_0000, 0, 1, 0, 8'h00, 1, "R12 R13 fill");
    end
    chk("R12 wrap at last slot", 32'(ctr_o), 0);

    // sweep entries, modes, tags, directions
    for (int s = 0; s < 7; s++) begin
      bit [31:0] sb = sz_bytes(m_sz[s]);
      bit [31:0] st = m_vb[s] & ~(sb - 1);
      for (int ai = 0; ai < 2; ai++)
        for (int p = 0; p < 2; p++)
          for (int w = 0; w < 2; w++)
            for (int sv_i = 0; sv_i < 2; sv_i++)
              for (int ak = 0; ak < 2; ak++)
                look(ai == 0 ? st + sb - 4 : st + sb, w[0], p[0], sv_i[0],
                     ak == 0 ? 8'(s) : 8'h77, 1, "R3 R13 sweep");
    end

    // fixed windows, both modes
    foreach (m_vb[i]) ;
    for (int k = 0; k < 8; k++) begin
      bit [31:0] a;
      case (k)
        0: a = 32'h8000_0000; 1: a = 32'hBFFF_FFFC; 2: a = 32'hC000_0000; 3: a = 32'hDFFF_FFFC;
        4: a = 32'hE000_0000; 5: a = 32'hE400_0000; 6: a = 32'hE400_0004; default: a = 32'hFFFF_FFFC;
      endcase
      for (int p = 0; p < 2; p++)
        for (int w = 0; w < 2; w++)
          look(a, w[0], p[0], 0, 8'h00, 1, p ? "R5 fixed" : "R6 fixed");
    end

    // translation off
    look(32'h0010_0010, 1, 0, 0, 8'h00, 0, "R7 off");
    look(32'h1234_5678, 0, 0, 0, 8'h00, 0, "R7 off");
    look(32'h7FFF_FFFC, 1, 1, 0, 8'h00, 0, "R7 off");

    // fault then clean lookup keeps fault address
    look(32'h0700_0000, 0, 1, 0, 8'h00, 1, "R11 set");
    look(32'h1000_0000, 0, 1, 0, 8'h00, 0, "R11 hold");

    // no response without request
    @(negedge clk);
    chk("R1 idle", 32'(v_o), 0);
    summary();
  end
endmodule